// File: doc/BRIEF.md
# Automatic Pair Crossover Selector

This block decides whether a 10/100 Ethernet PHY drives its twisted pairs straight (MDI) or swapped (MDIX). A small control register holds two bits: an automatic-crossover enable and a force-crossover bit. The enable bit takes its reset value from a strap input. The force bit sets the crossed assignment on its own, whatever the other inputs are. Automatic selection runs only when the enable bit is set and the PHY is not in a fixed speed/duplex mode. When both register bits are clear, the pairs stay straight.

While automatic selection runs and no link is seen, the block swaps the pair assignment at the end of each dwell interval. Each interval is a fixed base period plus an offset taken from the low bits of a linear-feedback shift register. Because the intervals vary, two partners that use the same method do not keep swapping in step. When a link is detected, the selection and the dwell timer freeze, and the search carries on from the same point once the link drops. All ports are plain control and status pins. No data stream passes through the block, so no port has a handshake.

Top module: `mdix_xover_sel`

## Requirements
- R1: The reset is synchronous and active low. During reset the enable bit loads `strap_auto`, the force bit clears, and `mdix_sel` reads 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata[1]` into the enable bit and `cfg_wdata[0]` into the force bit. The new values appear on `cfg_rdata` (same bit positions) after that clock edge. Without `cfg_we` both bits keep their values.
- R3: While the force bit is 1, `mdix_sel` is 1 (crossed), whatever the values of the enable bit, `forced_mode` and `link_up`.
- R4: While the enable bit and the force bit are both 0, `mdix_sel` is 0 (straight).
- R5: While `forced_mode` is high, automatic selection is suspended and `mdix_sel` is 0 unless the force bit is set. At each such edge the search state returns to straight and the dwell timer reloads from the current LFSR value.
- R6: A dwell interval lasts DWELL_BASE + (L mod 2^OFS_W) searching clock edges, where L is the LFSR value that belongs to the interval. The first interval after reset uses LFSR_SEED. The selection toggles on the last edge of the interval.
- R7: The LFSR shifts left by one at each toggle and takes as its new bit 0 the XOR of the state bits that LFSR_TAPS selects. The default 8-bit taps are bits 7, 5, 4 and 3. The LFSR never holds zero.
- R8: While `link_up` is high, both the selection and the dwell timer are frozen. Searching resumes from the frozen count when the link drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_auto | input | 1 | Reset value of the automatic-crossover enable |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Bit 1 enable, bit 0 force |
| cfg_rdata | output | 2 | Control register contents, same layout |
| forced_mode | input | 1 | PHY runs a fixed speed/duplex mode |
| link_up | input | 1 | Link detected |
| mdix_sel | output | 1 | 0 straight pairs, 1 crossed pairs |

## Verification
The bench uses DWELL_BASE 4, a 3-bit offset and the 8-bit LFSR seeded with 0xA5. With these values each dwell lasts between 4 and 11 cycles, so several toggles fit into a few dozen cycles. The first two intervals are known exactly: 9 cycles from the seed, then 6 cycles from the next LFSR value 0x4A. Short stimulus segments can therefore end in the middle of a dwell and show that the count is frozen under link, reloaded under fixed mode, and overridden by the force bit.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  typedef enum logic {PAIR_STRAIGHT = 1'b0, PAIR_CROSSED = 1'b1} pair_e;
  localparam int unsigned CFG_W     = 2;
  localparam int unsigned CFG_FORCE = 0;
  localparam int unsigned CFG_AUTO  = 1;
endpackage

// File: rtl/mdix_cfg_reg.sv
module mdix_cfg_reg
  import mdix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_auto,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             auto_en,
  output logic             force_x
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_en <= strap_auto;
      force_x <= 1'b0;
    end else if (we) begin
      auto_en <= wdata[CFG_AUTO];
      force_x <= wdata[CFG_FORCE];
    end
  end

  // R2: bits only move on a write strobe
  p_cfg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({auto_en, force_x}));
endmodule

// File: rtl/mdix_lfsr.sv
module mdix_lfsr #(
  parameter int unsigned      W    = 8,
  parameter logic [W-1:0]     TAPS = 8'hB8,
  parameter logic [W-1:0]     SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {q[W-2:0], ^(q & TAPS)};

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= SEED;
    else if (adv) q <= nxt;
  end

  // R7: register never locks up at zero
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
  // R7: state only moves on an advance
  p_lfsr_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/mdix_dwell.sv
module mdix_dwell #(
  parameter int unsigned          BASE   = 1024,
  parameter int unsigned          OFS_W  = 8,
  parameter int unsigned          LFSR_W = 8,
  parameter logic [LFSR_W-1:0]    SEED   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              hold,
  input  logic [LFSR_W-1:0] rnd_q,
  input  logic [LFSR_W-1:0] rnd_nxt,
  output logic              adv,
  output logic              state
);
  localparam int unsigned CNT_W = $clog2(BASE + (1 << OFS_W)) + 1;

  logic [CNT_W-1:0] left_q;

  function automatic logic [CNT_W-1:0] dwell_of(input logic [OFS_W-1:0] r);
    return CNT_W'(BASE) + CNT_W'(r);
  endfunction

  assign adv = active && !hold && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= 1'b0;
      left_q <= dwell_of(SEED[OFS_W-1:0]);
    end else if (!active) begin
      state  <= 1'b0;
      left_q <= dwell_of(rnd_q[OFS_W-1:0]);
    end else if (!hold) begin
      if (adv) begin
        state  <= ~state;
        left_q <= dwell_of(rnd_nxt[OFS_W-1:0]);
      end else begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  // R8: link freezes selection and count
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active && hold |=> $stable(state) && $stable(left_q));
  // R5: suspended search returns to straight
  p_idle_straight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !state);
  // R6: no toggle before the dwell ends
  p_no_early_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active && !hold && (left_q != CNT_W'(1)) |=> $stable(state));
  // R6: the count never reaches zero
  p_dwell_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    left_q != '0);
endmodule

// File: rtl/mdix_xover_sel.sv
module mdix_xover_sel
  import mdix_pkg::*;
#(
  parameter int unsigned          DWELL_BASE = 1024,
  parameter int unsigned          OFS_W      = 8,
  parameter int unsigned          LFSR_W     = 8,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS  = 8'hB8,
  parameter logic [LFSR_W-1:0]    LFSR_SEED  = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_auto,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] cfg_rdata,
  input  logic       forced_mode,
  input  logic       link_up,
  output logic       mdix_sel
);
  logic              auto_en, force_x, active, adv, hunt_state;
  logic [LFSR_W-1:0] rnd_q, rnd_nxt;

  mdix_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_auto(strap_auto),
    .we(cfg_we), .wdata(cfg_wdata), .auto_en(auto_en), .force_x(force_x)
  );

  mdix_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .q(rnd_q), .nxt(rnd_nxt)
  );

  mdix_dwell #(.BASE(DWELL_BASE), .OFS_W(OFS_W), .LFSR_W(LFSR_W), .SEED(LFSR_SEED)) u_dwell (
    .clk(clk), .rst_n(rst_n), .active(active), .hold(link_up),
    .rnd_q(rnd_q), .rnd_nxt(rnd_nxt), .adv(adv), .state(hunt_state)
  );

  assign active    = auto_en && !forced_mode;
  assign cfg_rdata = {auto_en, force_x};

  pair_e pair;
  always_comb begin
    if (force_x)                   pair = PAIR_CROSSED;
    else if (active && hunt_state) pair = PAIR_CROSSED;
    else                           pair = PAIR_STRAIGHT;
  end
  assign mdix_sel = (pair == PAIR_CROSSED);

  // R3: force bit overrides everything
  p_force_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_FORCE] |-> mdix_sel);
  // R4: both bits clear means straight pairs
  p_off_straight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 2'b00) |-> !mdix_sel);
  // R5: fixed mode without force gives straight pairs
  p_fixed_straight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    forced_mode && !cfg_rdata[CFG_FORCE] |-> !mdix_sel);
endmodule

// File: tb/mdix_xover_sel_test.sv
module mdix_xover_sel_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_auto = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic [1:0] cfg_rdata;
  logic       forced_mode = 1'b0;
  logic       link_up = 1'b0;
  logic       mdix_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdix_xover_sel #(.DWELL_BASE(4), .OFS_W(3), .LFSR_W(8),
                   .LFSR_TAPS(8'hB8), .LFSR_SEED(8'hA5)) uut (
    .clk(clk), .rst_n(rst_n), .strap_auto(strap_auto), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .forced_mode(forced_mode),
    .link_up(link_up), .mdix_sel(mdix_sel)
  );

  // reference state built from the requirements
  logic       m_auto, m_force, m_state;
  logic [7:0] m_lfsr;
  int         m_left;

  function automatic logic [7:0] lfsr_after(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic int dwell_len(input logic [7:0] s);
    return 4 + int'(s[2:0]);
  endfunction

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic exp_sel();
    return m_force | (m_auto & ~forced_mode & m_state);
  endfunction

  function automatic string sel_tag();
    if (m_force)           return "R3";
    else if (!m_auto)      return "R4";
    else if (forced_mode)  return "R5";
    else if (link_up)      return "R8";
    else                   return "R6";
  endfunction

  task automatic model_reset(input logic strap);
    m_auto = strap; m_force = 1'b0; m_state = 1'b0;
    m_lfsr = 8'hA5; m_left = dwell_len(8'hA5);
  endtask

  task automatic step(input logic lnk, input logic fx, input logic we, input logic [1:0] wd);
    logic act;
    link_up = lnk; forced_mode = fx; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    act = m_auto & ~fx;
    if (!act) begin
      m_state = 1'b0; m_left = dwell_len(m_lfsr);
    end else if (!lnk) begin
      if (m_left == 1) begin
        m_state = ~m_state; m_lfsr = lfsr_after(m_lfsr); m_left = dwell_len(m_lfsr);
      end else m_left--;
    end
    if (we) begin m_auto = wd[1]; m_force = wd[0]; end
    @(negedge clk);
    cfg_we = 1'b0;
    check({1'b0, mdix_sel}, {1'b0, exp_sel()}, sel_tag());
    check(cfg_rdata, {m_auto, m_force}, "R2");
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_auto = strap; cfg_we = 1'b0; link_up = 1'b0; forced_mode = 1'b0;
    repeat (2) @(negedge clk);
    model_reset(strap);
    rst_n = 1'b1;
    check({1'b0, mdix_sel}, 2'b00, "R1");
    check(cfg_rdata, {strap, 1'b0}, "R1");
  endtask

  // {link, forced, we, wdata[1:0], cycles[7:0]}
  localparam logic [12:0] VEC [11] = '{
    {1'b0, 1'b0, 1'b1, 2'b10, 8'd20},
    {1'b1, 1'b0, 1'b0, 2'b00, 8'd10},
    {1'b0, 1'b0, 1'b0, 2'b00, 8'd15},
    {1'b0, 1'b1, 1'b0, 2'b00, 8'd6},
    {1'b0, 1'b0, 1'b0, 2'b00, 8'd12},
    {1'b0, 1'b0, 1'b1, 2'b11, 8'd5},
    {1'b1, 1'b1, 1'b0, 2'b00, 8'd4},
    {1'b0, 1'b0, 1'b1, 2'b01, 8'd6},
    {1'b0, 1'b0, 1'b1, 2'b00, 8'd10},
    {1'b1, 1'b0, 1'b0, 2'b00, 8'd3},
    {1'b0, 1'b0, 1'b1, 2'b10, 8'd25}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: strap clear gives disabled automatic mode
    do_reset(1'b0);
    step(1'b0, 1'b0, 1'b0, 2'b00);
    // R1: strap set gives enabled automatic mode
    do_reset(1'b1);

    // R6 and R7: first dwell 9 cycles (seed 0xA5), second 6 cycles (0x4A)
    for (int i = 1; i <= 8; i++) step(1'b0, 1'b0, 1'b0, 2'b00);
    check({1'b0, mdix_sel}, 2'b00, "R6");
    step(1'b0, 1'b0, 1'b0, 2'b00);
    check({1'b0, mdix_sel}, 2'b01, "R6");
    for (int i = 1; i <= 5; i++) step(1'b0, 1'b0, 1'b0, 2'b00);
    check({1'b0, mdix_sel}, 2'b01, "R7");
    step(1'b0, 1'b0, 1'b0, 2'b00);
    check({1'b0, mdix_sel}, 2'b00, "R7");

    // R8: link in crossed state holds it through a long window
    for (int i = 1; i <= 9; i++) step(1'b0, 1'b0, 1'b0, 2'b00);
    for (int i = 1; i <= 30; i++) step(1'b1, 1'b0, 1'b0, 2'b00);

    // table walk
    for (int v = 0; v < 11; v++) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++)
        step(VEC[v][12], VEC[v][11], (c == 0) ? VEC[v][10] : 1'b0, VEC[v][9:8]);
    end

    // R3: force with auto off, fixed mode and link all active
    step(1'b1, 1'b1, 1'b1, 2'b01);
    check({1'b0, mdix_sel}, 2'b01, "R3");
    // R4: clear everything, search cannot move the output
    step(1'b0, 1'b0, 1'b1, 2'b00);
    for (int i = 1; i <= 20; i++) step(1'b0, 1'b0, 1'b0, 2'b00);
    check({1'b0, mdix_sel}, 2'b00, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule